// File: doc/BRIEF.md
# Write Protection Gate for a Serial Byte Memory

This block sits beside the command controller of a two-wire serial byte memory and decides whether a write may go into the array. It combines two independent locks. The first is a one-time flag, set by a dedicated protect-register command, that locks the lower half of the address space for good. The second is an external write-protect pin; while it is high, every address is locked. A low-supply indication also inhibits writing.

The controller reports bus phases through single-cycle markers: a START, the SCL rising edge that latches bit 0 of the first data byte, and a STOP. The bit-0 marker opens a cancel window. Before that marker the pin level is ignored. From that marker until the internal write cycle ends, a high pin or a low supply cancels the write at once and raises a one-cycle abort request. If the cancel lands inside the write cycle, the target byte must be treated as undefined. The block times the write cycle itself, and the protect command only takes effect when its full cycle completes.

Top module: `wprot_unit`

## Requirements
- R1: After reset, lock_flag, wr_ok, wr_busy and abort_req are all 0.
- R2: Between a START and the first-data bit-0 marker, the level of wp_pin has no effect: no abort_req is raised and the write that follows is not affected.
- R3: One cycle after the bit-0 marker, wr_ok is 1 when the pin is low, the supply is good and the target is not locked. The target's half is taken from tgt_addr bit 7 (0 = lower half 00h-7Fh) at the marker.
- R4: A STOP while wr_ok is 1 starts a write cycle: wr_busy is high for exactly WR_CYCLES clock cycles and then falls with no abort_req.
- R5: While the window is open and before the STOP, wp_pin going high (seen after a two-flop synchronizer) produces a one-cycle abort_req, drops wr_ok, and a later STOP starts no cycle.
- R6: wp_pin going high during the write cycle raises abort_req and ends wr_busy in the same cycle, without waiting for the cycle to finish.
- R7: A protect command (prot_sel = 1 at the marker) whose cycle completes sets lock_flag in the cycle wr_busy falls. lock_flag never clears while rst is low.
- R8: With lock_flag set, a write whose tgt_addr bit 7 is 0 is refused: wr_ok stays 0 and a STOP starts no cycle. A write whose bit 7 is 1 is still accepted.
- R9: A protect command issued while lock_flag is already set is refused. wr_ok stays 0 and no cycle starts.
- R10: low_supply high acts like the pin: inside the window it raises abort_req, and no write cycle ever starts while it is high.
- R11: START, bit-0 and STOP markers that arrive during a write cycle are ignored. The cycle keeps its length and no second cycle follows.
- R12: A repeated START before the STOP abandons the pending write without abort_req. wr_ok falls and a STOP starts no cycle.
- R13: A protect command cancelled by wp_pin during its cycle leaves lock_flag at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wp_pin | input | 1 | Asynchronous write-protect pin, high = lock all |
| low_supply | input | 1 | Low-supply indication, high = inhibit writes |
| start_seen | input | 1 | One-cycle marker for a START condition |
| d0_mark | input | 1 | One-cycle marker for the SCL edge latching bit 0 of the first data byte |
| stop_seen | input | 1 | One-cycle marker for a STOP condition |
| prot_sel | input | 1 | 1 = the current command writes the protect register, sampled at d0_mark |
| tgt_addr | input | 8 | Target word address, sampled at d0_mark |
| wr_ok | output | 1 | Pending or running write is permitted |
| wr_busy | output | 1 | Internal write cycle in progress |
| abort_req | output | 1 | One-cycle request to cancel the write under way |
| lock_flag | output | 1 | One-time lower-half lock state |

## Verification
The bench raises the pin before the bit-0 marker and again just after it, so a window that opened at START would abort a legal write, and one that opened late would let a cancelled write commit. It cancels writes in the middle of a cycle, including a protect command, so that a design deciding only at STOP, or one that sets the lock when the cycle starts, is caught by the length of wr_busy or by lock_flag. It sends markers during a busy cycle and a repeated START before the STOP, which would show up as an extra or lengthened cycle. It checks the lower and upper halves after locking and repeats the protect command, which a design ignoring bit 7 or re-arming the lock would accept.

// File: rtl/wprot_pkg.sv
package wprot_pkg;
  typedef enum logic [1:0] {
    WS_IDLE  = 2'd0,
    WS_ARMED = 2'd1,
    WS_BUSY  = 2'd2
  } wstate_t;
endpackage

// File: rtl/wprot_sync.sv
module wprot_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= d_in;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d_in};
      end
    end
  endgenerate

  assign d_out = chain[STAGES-1];
endmodule

// File: rtl/wprot_lock.sv
module wprot_lock (
  input  logic clk,
  input  logic rst,
  input  logic set_req,
  output logic lock_q
);
  // once set, only a reset (fresh device) returns it to 0
  always_ff @(posedge clk) begin
    if (rst)          lock_q <= 1'b0;
    else if (set_req) lock_q <= 1'b1;
  end
endmodule

// File: rtl/wprot_ctrl.sv
module wprot_ctrl
  import wprot_pkg::*;
#(
  parameter int AW        = 8,
  parameter int WR_CYCLES = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_seen,
  input  logic          d0_mark,
  input  logic          stop_seen,
  input  logic          prot_sel,
  input  logic [AW-1:0] tgt_addr,
  input  logic          inhibit,
  input  logic          lock_q,
  output logic          wr_ok,
  output logic          busy,
  output logic          abort_req,
  output logic          lock_set
);
  localparam int TW = (WR_CYCLES > 2) ? $clog2(WR_CYCLES) : 1;
  localparam logic [TW-1:0] TMR_LOAD = TW'(WR_CYCLES - 1);

  wstate_t       st_q, st_n;
  logic [TW-1:0] tmr_q, tmr_n;
  logic          low_q, low_n;
  logic          prot_q, prot_n;
  logic          abort_n, ok_n;
  logic          blocked_q, blocked_n;

  // refusal for the latched target, current lock state
  assign blocked_q = lock_q & (prot_q | low_q);
  assign blocked_n = lock_q & (prot_n | low_n);

  always_comb begin
    st_n    = st_q;
    tmr_n   = tmr_q;
    low_n   = low_q;
    prot_n  = prot_q;
    abort_n = 1'b0;
    unique case (st_q)
      WS_IDLE: begin
        if (d0_mark) begin
          st_n   = WS_ARMED;
          low_n  = ~tgt_addr[AW-1];
          prot_n = prot_sel;
        end
      end
      WS_ARMED: begin
        if (inhibit) begin
          abort_n = 1'b1;
          st_n    = WS_IDLE;
        end else if (start_seen) begin
          st_n = WS_IDLE;
        end else if (stop_seen) begin
          if (!blocked_q) begin
            st_n  = WS_BUSY;
            tmr_n = TMR_LOAD;
          end else begin
            st_n = WS_IDLE;
          end
        end
      end
      WS_BUSY: begin
        if (inhibit) begin
          abort_n = 1'b1;
          st_n    = WS_IDLE;
        end else if (tmr_q == '0) begin
          st_n = WS_IDLE;
        end else begin
          tmr_n = tmr_q - 1'b1;
        end
      end
      default: st_n = WS_IDLE;
    endcase
    ok_n = (st_n != WS_IDLE) && !inhibit && !blocked_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= WS_IDLE;
      tmr_q     <= '0;
      low_q     <= 1'b0;
      prot_q    <= 1'b0;
      abort_req <= 1'b0;
      wr_ok     <= 1'b0;
    end else begin
      st_q      <= st_n;
      tmr_q     <= tmr_n;
      low_q     <= low_n;
      prot_q    <= prot_n;
      abort_req <= abort_n;
      wr_ok     <= ok_n;
    end
  end

  assign busy     = (st_q == WS_BUSY);
  assign lock_set = (st_q == WS_BUSY) && (tmr_q == '0) && !inhibit && prot_q;
endmodule

// File: rtl/wprot_unit.sv
module wprot_unit #(
  parameter int AW          = 8,
  parameter int WR_CYCLES   = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wp_pin,
  input  logic          low_supply,
  input  logic          start_seen,
  input  logic          d0_mark,
  input  logic          stop_seen,
  input  logic          prot_sel,
  input  logic [AW-1:0] tgt_addr,
  output logic          wr_ok,
  output logic          wr_busy,
  output logic          abort_req,
  output logic          lock_flag
);
  logic wp_s;
  logic inhibit;
  logic lock_set;

  wprot_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_in(wp_pin), .d_out(wp_s)
  );

  assign inhibit = wp_s | low_supply;

  wprot_lock u_lock (
    .clk(clk), .rst(rst), .set_req(lock_set), .lock_q(lock_flag)
  );

  wprot_ctrl #(.AW(AW), .WR_CYCLES(WR_CYCLES)) u_ctrl (
    .clk(clk), .rst(rst),
    .start_seen(start_seen), .d0_mark(d0_mark), .stop_seen(stop_seen),
    .prot_sel(prot_sel), .tgt_addr(tgt_addr),
    .inhibit(inhibit), .lock_q(lock_flag),
    .wr_ok(wr_ok), .busy(wr_busy), .abort_req(abort_req), .lock_set(lock_set)
  );
endmodule

// File: rtl/wprot_unit_chk.sv
module wprot_unit_chk (
  input logic clk,
  input logic rst,
  input logic stop_seen,
  input logic low_supply,
  input logic wr_ok,
  input logic wr_busy,
  input logic abort_req,
  input logic lock_flag
);
  p_lock_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    lock_flag |=> lock_flag);
  p_lock_after_cycle_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(lock_flag) |-> $past(wr_busy));
  p_abort_drops_r5: assert property (@(posedge clk) disable iff (rst)
    abort_req |-> (!wr_busy && !wr_ok));
  p_abort_single_r6: assert property (@(posedge clk) disable iff (rst)
    abort_req |=> !abort_req);
  p_cycle_from_stop_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_busy) |-> $past(stop_seen));
  p_busy_is_ok_r4: assert property (@(posedge clk) disable iff (rst)
    wr_busy |-> wr_ok);
  p_lowv_no_cycle_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_busy) |-> !$past(low_supply));
endmodule

bind wprot_unit wprot_unit_chk u_chk (
  .clk(clk), .rst(rst), .stop_seen(stop_seen), .low_supply(low_supply),
  .wr_ok(wr_ok), .wr_busy(wr_busy), .abort_req(abort_req), .lock_flag(lock_flag)
);

// File: tb/test_wprot_unit.sv
module test_wprot_unit;
  localparam int WR = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wp_pin = 1'b0, low_supply = 1'b0;
  logic       start_seen = 1'b0, d0_mark = 1'b0, stop_seen = 1'b0, prot_sel = 1'b0;
  logic [7:0] tgt_addr = 8'h00;
  logic       wr_ok, wr_busy, abort_req, lock_flag;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  typedef struct {
    int    kind;  // 0 = completed cycle, 1 = abort
    int    len;   // busy cycles, -1 = any
    string tag;
  } ev_t;
  ev_t exp_q[$];

  always #2 clk = ~clk;

  wprot_unit #(.AW(8), .WR_CYCLES(WR), .SYNC_STAGES(2)) i_wprot_unit (
    .clk(clk), .rst(rst), .wp_pin(wp_pin), .low_supply(low_supply),
    .start_seen(start_seen), .d0_mark(d0_mark), .stop_seen(stop_seen),
    .prot_sel(prot_sel), .tgt_addr(tgt_addr),
    .wr_ok(wr_ok), .wr_busy(wr_busy), .abort_req(abort_req), .lock_flag(lock_flag)
  );

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_ev(int kind, int len, string tag);
    ev_t e;
    e.kind = kind; e.len = len; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic do_start();
    start_seen = 1'b1; step(); start_seen = 1'b0;
  endtask
  task automatic do_d0(logic [7:0] a, logic p);
    tgt_addr = a; prot_sel = p; d0_mark = 1'b1; step(); d0_mark = 1'b0;
  endtask
  task automatic do_stop();
    stop_seen = 1'b1; step(); stop_seen = 1'b0;
  endtask
  task automatic sample_check(string tag, int act_sel, int exp);
    int a;
    @(negedge clk);
    case (act_sel)
      0: a = wr_ok;
      1: a = wr_busy;
      2: a = abort_req;
      default: a = lock_flag;
    endcase
    check(tag, a, exp);
    step();
  endtask

  // monitor: turns end-of-cycle and abort observations into events
  int  blen = 0;
  bit  prev_busy = 1'b0;
  always @(negedge clk) begin
    if (rst) begin
      blen = 0; prev_busy = 1'b0;
    end else begin
      if (wr_busy) blen++;
      if (abort_req || (prev_busy && !wr_busy)) begin
        ev_t got;
        got.kind = abort_req ? 1 : 0;
        got.len  = blen;
        total++;
        if (exp_q.size() == 0) begin
          bad++;
          $display("FAIL unexpected event: actual kind=%0d len=%0d expected none", got.kind, got.len);
        end else begin
          ev_t e;
          e = exp_q.pop_front();
          if (got.kind != e.kind || (e.len >= 0 && got.len != e.len)) begin
            bad++;
            $display("FAIL %s: actual kind=%0d len=%0d expected kind=%0d len=%0d",
                     e.tag, got.kind, got.len, e.kind, e.len);
          end
        end
        blen = 0;
      end
      prev_busy = wr_busy;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step(5);
    rst = 1'b0;
    @(negedge clk);
    check("R1 lock", lock_flag, 0);
    check("R1 ok", wr_ok, 0);
    check("R1 busy", wr_busy, 0);
    check("R1 abort", abort_req, 0);
    step();

    // R2 / R3 / R4: pin pulses before the marker are ignored
    do_start();
    wp_pin = 1'b1; step(6); wp_pin = 1'b0; step(4);
    sample_check("R2 ok before marker", 0, 0);
    do_d0(8'h10, 1'b0); step(2);
    sample_check("R3 ok after marker", 0, 1);
    expect_ev(0, WR, "R4 cycle length");
    do_stop(); step(WR + 4);
    sample_check("R4 busy ended", 1, 0);

    // R5: pin high inside window before STOP
    do_start(); do_d0(8'h90, 1'b0); step(2);
    expect_ev(1, 0, "R5 abort before stop");
    wp_pin = 1'b1; step(6);
    sample_check("R5 ok dropped", 0, 0);
    do_stop(); step(2);
    sample_check("R5 no cycle", 1, 0);
    wp_pin = 1'b0; step(4);

    // R6: pin high during the cycle
    do_start(); do_d0(8'h20, 1'b0); step(2); do_stop();
    expect_ev(1, -1, "R6 abort in cycle");
    step(8); wp_pin = 1'b1; step(6);
    sample_check("R6 busy ended early", 1, 0);
    wp_pin = 1'b0; step(4);

    // R11: markers during the cycle are ignored
    do_start(); do_d0(8'h40, 1'b0); step(2);
    expect_ev(0, WR, "R11 cycle length kept");
    do_stop(); step(3);
    do_start(); do_d0(8'h00, 1'b1); do_stop();
    step(WR + 4);
    sample_check("R11 no second cycle", 1, 0);

    // R12: repeated START abandons the pending write
    do_start(); do_d0(8'h30, 1'b0); step(2);
    do_start(); step(1);
    sample_check("R12 ok dropped", 0, 0);
    do_stop(); step(2);
    sample_check("R12 no cycle", 1, 0);

    // R13: protect command cancelled mid cycle
    do_start(); do_d0(8'h00, 1'b1); step(2); do_stop();
    expect_ev(1, -1, "R13 protect abort");
    step(5); wp_pin = 1'b1; step(5); wp_pin = 1'b0; step(4);
    sample_check("R13 lock stays clear", 3, 0);

    // R7: protect command completes
    do_start(); do_d0(8'h00, 1'b1); step(2);
    expect_ev(0, WR, "R7 protect cycle");
    do_stop(); step(WR + 3);
    sample_check("R7 lock set", 3, 1);

    // R8: lower half refused, upper half accepted
    do_start(); do_d0(8'h05, 1'b0); step(2);
    sample_check("R8 lower refused", 0, 0);
    do_stop(); step(2);
    sample_check("R8 lower no cycle", 1, 0);
    do_start(); do_d0(8'hA0, 1'b0); step(2);
    sample_check("R8 upper accepted", 0, 1);
    expect_ev(0, WR, "R8 upper cycle");
    do_stop(); step(WR + 3);

    // R9: second protect command refused
    do_start(); do_d0(8'h00, 1'b1); step(2);
    sample_check("R9 protect refused", 0, 0);
    do_stop(); step(2);
    sample_check("R9 no cycle", 1, 0);
    sample_check("R9 lock kept", 3, 1);

    // R10: low supply inside the window and during a cycle
    do_start(); do_d0(8'hC0, 1'b0); step(1);
    expect_ev(1, 0, "R10 low supply before stop");
    low_supply = 1'b1; step(3);
    sample_check("R10 ok dropped", 0, 0);
    do_stop(); step(2);
    sample_check("R10 no cycle", 1, 0);
    low_supply = 1'b0; step(2);
    do_start(); do_d0(8'hC1, 1'b0); step(2); do_stop();
    expect_ev(1, -1, "R10 low supply in cycle");
    step(4); low_supply = 1'b1; step(3);
    sample_check("R10 busy ended", 1, 0);
    low_supply = 1'b0; step(10);

    check("R4 all expected events seen", exp_q.size(), 0);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule